// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into an on-chip memory that it treats as a ring. While capture runs, each word accepted on a valid/ready input is written at the write pointer, and the pointer wraps at the end of the memory. Once the pointer has wrapped, the block reports that the buffer is full, and from then on the oldest words are overwritten.

Capture ends in one of three ways. Software can clear the enable bit. A trigger pulse can start a countdown of a programmed number of further words. A manual flush can be set up to halt capture when it completes, and a trigger can also be set up to start such a flush.

When capture has stopped and the block reports ready, software drains the buffer through a read-data register. The words come out oldest first. Once every stored word has been returned, the register reads as all ones.

Top module: `trc_ring_capture`

## Requirements
- R1: After reset the status register (offset 3) reads 4: bit 2 (ready) is set, and bit 0 (full) and bit 1 (triggered) are clear. The size register (offset 2) reads the depth in words, the control register (offset 0) reads 0, and `tr_ready` is low.
- R2: Writing 1 to control bit 0 while it is 0 starts capture. Starting capture clears status bits 0, 1 and 2 and sets the write pointer (offset 6) and the read pointer (offset 5) to 0.
- R3: While capture is not running, `tr_ready` is low and no word is stored, so the write pointer does not move.
- R4: Each accepted word is stored at the write pointer, and the pointer then advances modulo the depth. Writing the last address sets status bit 0 (full), which stays set until the next start.
- R5: Writing 0 to control bit 0 stops capture. Status bit 2 (ready) is set on the cycle after capture stops.
- R6: When capture has stopped, the read pointer points at the oldest word: the write pointer if full is set, otherwise 0. Each read of offset 4 returns the next stored word in capture order and advances the read pointer. Once all stored words have been returned, offset 4 reads 0xFFFFFFFF.
- R7: When flush-control bit 8 (offset 8) is set, the first trigger pulse of a capture sets status bit 1 and loads the trigger count (offset 7). Capture then stops after exactly that many more words. A count of 0 lets no further word in.
- R8: When flush-control bit 8 is clear, the trigger input is ignored and status bit 1 stays 0.
- R9: Writing flush-control bit 6 as 1 starts a flush. Bit 6 reads 1 on the next cycle and then clears itself when the flush completes, one cycle later.
- R10: When flush-control bit 12 is set, completion of a flush stops capture. When it is clear, capture continues after the flush.
- R11: When flush-control bit 5 is set, a trigger event starts a flush.
- R12: The mode register (offset 1) reads back its 2-bit value: 0 selects circular buffer, 1 software FIFO, 2 hardware FIFO. Words are accepted only in mode 0.
- R13: Reads of unmapped offsets return 0. Offset 4 returns 0xFFFFFFFF while capture is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; advances readout at offset 4 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on the address |
| tr_valid | input | 1 | Trace word valid |
| tr_data | input | 32 | Trace word |
| tr_ready | output | 1 | Trace word accepted when high together with valid |
| trig_in | input | 1 | Trigger pulse |

## Verification
The bench builds the block with a depth of 16 words and an 8-bit trigger count. With the small depth, a 20-word capture wraps the pointer in a few cycles, so the full flag and oldest-first readout starting mid-ring are checked against a scoreboard that keeps only the last 16 words. The narrow count still covers the zero-count case and a count large enough to be overtaken by a flush-on-trigger stop.

// File: rtl/trc_pkg.sv
package trc_pkg;

   // register word offsets
   localparam int unsigned OFF_CTRL  = 0;
   localparam int unsigned OFF_MODE  = 1;
   localparam int unsigned OFF_SIZE  = 2;
   localparam int unsigned OFF_STAT  = 3;
   localparam int unsigned OFF_RDAT  = 4;
   localparam int unsigned OFF_RPTR  = 5;
   localparam int unsigned OFF_WPTR  = 6;
   localparam int unsigned OFF_TRGC  = 7;
   localparam int unsigned OFF_FLSH  = 8;

   // flush-control field positions
   localparam int unsigned FL_ON_TRIG_BIT = 5;
   localparam int unsigned FL_REQ_BIT     = 6;
   localparam int unsigned FL_TRIGIN_BIT  = 8;
   localparam int unsigned FL_STOP_BIT    = 12;

   localparam int unsigned WORD_W = 32;
   localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

   typedef enum logic [1:0] {
      MODE_CIRC   = 2'd0,
      MODE_SWFIFO = 2'd1,
      MODE_HWFIFO = 2'd2
   } trc_mode_e;

endpackage

// File: rtl/trc_ring_ram.sv
module trc_ring_ram #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/trc_capture_ctl.sv
module trc_capture_ctl #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned TRG_W = 16,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             flush_req,
   input  logic             mode_ok,
   input  logic             trig_on_in,
   input  logic             flush_on_trig,
   input  logic             stop_on_flush,
   input  logic [TRG_W-1:0] trg_count,
   input  logic             tr_valid,
   input  logic             trig_in,
   output logic             tr_ready,
   output logic             mem_we,
   output logic [AW-1:0]    wptr,
   output logic             full,
   output logic             trig_seen,
   output logic             ready,
   output logic             load_pulse,
   output logic             flush_busy
);

   logic             running_q;
   logic [AW-1:0]    wptr_q;
   logic             full_q;
   logic             trig_q;
   logic [TRG_W-1:0] trig_left_q;
   logic             flush_q;
   logic             ready_q;

   logic gate_done, accept, trig_evt, last_word, stop_now;

   always_comb begin
      gate_done = trig_q && (trig_left_q == '0);
      tr_ready  = running_q && mode_ok && !gate_done;
      accept    = tr_valid && tr_ready;
      trig_evt  = trig_in && trig_on_in && running_q && !trig_q;
      last_word = trig_q && accept && (trig_left_q == TRG_W'(1));
      stop_now  = running_q && (stop_req || gate_done || last_word ||
                                (flush_q && stop_on_flush));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q   <= 1'b0;
         wptr_q      <= '0;
         full_q      <= 1'b0;
         trig_q      <= 1'b0;
         trig_left_q <= '0;
         flush_q     <= 1'b0;
         ready_q     <= 1'b1;
      end else if (start_req) begin
         running_q   <= 1'b1;
         wptr_q      <= '0;
         full_q      <= 1'b0;
         trig_q      <= 1'b0;
         trig_left_q <= '0;
         flush_q     <= 1'b0;
         ready_q     <= 1'b0;
      end else begin
         ready_q <= !running_q;
         if (stop_now) running_q <= 1'b0;
         if (accept) begin
            wptr_q <= wptr_q + 1'b1;
            if (wptr_q == AW'(DEPTH - 1)) full_q <= 1'b1;
         end
         if (trig_evt) begin
            trig_q      <= 1'b1;
            trig_left_q <= trg_count;
         end else if (accept && trig_q && (trig_left_q != '0)) begin
            trig_left_q <= trig_left_q - 1'b1;
         end
         if (flush_q)
            flush_q <= 1'b0;
         else if (flush_req || (trig_evt && flush_on_trig))
            flush_q <= 1'b1;
      end
   end

   assign mem_we     = accept;
   assign wptr       = wptr_q;
   assign full       = full_q;
   assign trig_seen  = trig_q;
   assign ready      = ready_q;
   assign load_pulse = !running_q && !ready_q;
   assign flush_busy = flush_q;

   // R4: an accepted word moves the write pointer by one
   p_wptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !start_req) |=> (wptr_q == $past(wptr_q) + 1'b1));

   // R4: full stays set until a new start
   p_full_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !start_req) |=> full_q);

   // R3: the pointer holds while nothing is accepted
   p_wptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !start_req) |=> $stable(wptr_q));

   // R7: an exhausted countdown ends capture
   p_count_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_done && running_q && !start_req) |=> !running_q);

   // R9: a flush lasts exactly one cycle
   p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |=> !flush_q);

   // R5: ready follows one cycle after capture stops
   p_ready_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(running_q) && !start_req) |=> ready_q);

endmodule

// File: rtl/trc_readout.sv
module trc_readout #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          load_pulse,
   input  logic          full,
   input  logic [AW-1:0] wptr,
   input  logic          ready,
   input  logic          rd_strobe,
   output logic [AW-1:0] rptr,
   output logic          have_data
);

   logic [AW-1:0] rptr_q;
   logic [AW:0]   left_q;

   assign have_data = ready && (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q <= '0;
         left_q <= '0;
      end else if (start_req) begin
         rptr_q <= '0;
         left_q <= '0;
      end else if (load_pulse) begin
         rptr_q <= full ? wptr : '0;
         left_q <= full ? (AW+1)'(DEPTH) : {1'b0, wptr};
      end else if (rd_strobe && have_data) begin
         rptr_q <= rptr_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   assign rptr = rptr_q;

   // R6: remaining words never exceed the ring depth
   p_left_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= (AW+1)'(DEPTH));

   // R6: each read consumes exactly one stored word
   p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && have_data && !start_req && !load_pulse)
      |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/trc_ring_capture.sv
module trc_ring_capture
   import trc_pkg::*;
#(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned TRG_W  = 16,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tr_valid,
   input  logic [31:0]       tr_data,
   output logic              tr_ready,
   input  logic              trig_in
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 4096) begin : g_bad_depth
         initial $error("DEPTH must be a power of two from 2 to 4096");
      end
      if (TRG_W < 1 || TRG_W > 32) begin : g_bad_trg
         initial $error("TRG_W must be 1 to 32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         initial $error("ADDR_W must be at least 4");
      end
   endgenerate

   logic             cap_en_q;
   trc_mode_e        mode_q;
   logic [TRG_W-1:0] trg_q;
   logic             cfg_on_trig_q, cfg_trigin_q, cfg_stop_q;

   logic hit_ctrl, hit_mode, hit_trgc, hit_flsh, hit_rdat;
   logic start_req, stop_req, flush_req, rd_strobe;

   always_comb begin
      hit_ctrl  = (reg_addr == ADDR_W'(OFF_CTRL));
      hit_mode  = (reg_addr == ADDR_W'(OFF_MODE));
      hit_trgc  = (reg_addr == ADDR_W'(OFF_TRGC));
      hit_flsh  = (reg_addr == ADDR_W'(OFF_FLSH));
      hit_rdat  = (reg_addr == ADDR_W'(OFF_RDAT));
      start_req = reg_we && hit_ctrl && reg_wdata[0] && !cap_en_q;
      stop_req  = reg_we && hit_ctrl && !reg_wdata[0];
      flush_req = reg_we && hit_flsh && reg_wdata[FL_REQ_BIT];
      rd_strobe = reg_re && hit_rdat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en_q      <= 1'b0;
         mode_q        <= MODE_CIRC;
         trg_q         <= '0;
         cfg_on_trig_q <= 1'b0;
         cfg_trigin_q  <= 1'b0;
         cfg_stop_q    <= 1'b0;
      end else if (reg_we) begin
         if (hit_ctrl) cap_en_q <= reg_wdata[0];
         if (hit_mode) mode_q   <= trc_mode_e'(reg_wdata[1:0]);
         if (hit_trgc) trg_q    <= reg_wdata[TRG_W-1:0];
         if (hit_flsh) begin
            cfg_on_trig_q <= reg_wdata[FL_ON_TRIG_BIT];
            cfg_trigin_q  <= reg_wdata[FL_TRIGIN_BIT];
            cfg_stop_q    <= reg_wdata[FL_STOP_BIT];
         end
      end
   end

   logic          mem_we, full, trig_seen, ready, load_pulse, flush_busy, have_data;
   logic [AW-1:0] wptr, rptr;
   logic [31:0]   ram_q;

   trc_capture_ctl #(.DEPTH(DEPTH), .TRG_W(TRG_W)) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_req     (start_req),
      .stop_req      (stop_req),
      .flush_req     (flush_req),
      .mode_ok       (mode_q == MODE_CIRC),
      .trig_on_in    (cfg_trigin_q),
      .flush_on_trig (cfg_on_trig_q),
      .stop_on_flush (cfg_stop_q),
      .trg_count     (trg_q),
      .tr_valid      (tr_valid),
      .trig_in       (trig_in),
      .tr_ready      (tr_ready),
      .mem_we        (mem_we),
      .wptr          (wptr),
      .full          (full),
      .trig_seen     (trig_seen),
      .ready         (ready),
      .load_pulse    (load_pulse),
      .flush_busy    (flush_busy)
   );

   trc_readout #(.DEPTH(DEPTH)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .load_pulse (load_pulse),
      .full       (full),
      .wptr       (wptr),
      .ready      (ready),
      .rd_strobe  (rd_strobe),
      .rptr       (rptr),
      .have_data  (have_data)
   );

   trc_ring_ram #(.DEPTH(DEPTH), .DATA_W(WORD_W)) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .waddr (wptr),
      .wdata (tr_data),
      .raddr (rptr),
      .rdata (ram_q)
   );

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         OFF_CTRL: reg_rdata = {31'd0, cap_en_q};
         OFF_MODE: reg_rdata = {30'd0, mode_q};
         OFF_SIZE: reg_rdata = 32'(DEPTH);
         OFF_STAT: reg_rdata = {29'd0, ready, trig_seen, full};
         OFF_RDAT: reg_rdata = have_data ? ram_q : EMPTY_WORD;
         OFF_RPTR: reg_rdata = 32'(rptr);
         OFF_WPTR: reg_rdata = 32'(wptr);
         OFF_TRGC: reg_rdata = 32'(trg_q);
         OFF_FLSH: begin
            reg_rdata[FL_ON_TRIG_BIT] = cfg_on_trig_q;
            reg_rdata[FL_REQ_BIT]     = flush_busy;
            reg_rdata[FL_TRIGIN_BIT]  = cfg_trigin_q;
            reg_rdata[FL_STOP_BIT]    = cfg_stop_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R12: no word is taken outside circular-buffer mode
   p_mode_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_CIRC) |-> !tr_ready);

   // R3: with the enable bit clear, the input stays closed
   p_idle_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en_q |-> !tr_ready);

endmodule

// File: tb/trc_ring_capture_tb.sv
module trc_ring_capture_tb;

   localparam int unsigned DEPTH = 16;
   localparam int unsigned TRG_W = 8;

   localparam logic [3:0] A_CTRL = 4'd0, A_MODE = 4'd1, A_SIZE = 4'd2, A_STAT = 4'd3,
                          A_RDAT = 4'd4, A_RPTR = 4'd5, A_WPTR = 4'd6, A_TRGC = 4'd7,
                          A_FLSH = 4'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tr_valid = 1'b0;
   logic [31:0] tr_data = '0;
   logic        tr_ready;
   logic        trig_in = 1'b0;

   int total = 0;
   int bad = 0;
   logic [31:0] exp_q[$];
   logic [31:0] seq = 32'hA000_0000;

   always #10 clk = ~clk;

   trc_ring_capture #(.DEPTH(DEPTH), .TRG_W(TRG_W), .ADDR_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tr_valid(tr_valid),
      .tr_data(tr_data), .tr_ready(tr_ready), .trig_in(trig_in)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); #1 reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_re = 1'b1;
      #1 d = reg_rdata;
      @(posedge clk); #1 reg_re = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   // driver: offers one word, records it as expected when it is taken
   task automatic push(output bit ok);
      @(negedge clk); tr_valid = 1'b1; tr_data = seq;
      ok = tr_ready;
      @(posedge clk); #1 tr_valid = 1'b0;
      if (ok) begin
         exp_q.push_back(seq);
         if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
      end
      seq++;
   endtask

   task automatic push_n(input int n, output int taken);
      bit ok;
      taken = 0;
      for (int i = 0; i < n; i++) begin
         push(ok);
         if (ok) taken++;
      end
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig_in = 1'b1;
      @(posedge clk); #1 trig_in = 1'b0;
   endtask

   // monitor side: pops expected words as the design returns them
   task automatic drain(input string tag);
      logic [31:0] v;
      while (exp_q.size() > 0) begin
         rd(A_RDAT, v);
         check(tag, v, exp_q.pop_front());
      end
      rd(A_RDAT, v);
      check({tag, " end marker"}, v, 32'hFFFF_FFFF);
   endtask

   task automatic restart();
      wr(A_CTRL, 32'd0);
      wr(A_CTRL, 32'd1);
      exp_q.delete();
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      bit ok;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd_chk(A_STAT, 32'd4, "R1 status");
      rd_chk(A_SIZE, DEPTH, "R1 size");
      rd_chk(A_CTRL, 32'd0, "R1 ctrl");
      check("R1 tr_ready", {31'd0, tr_ready}, 32'd0);

      // R3 disabled input ignored
      push(ok);
      check("R3 accept while off", {31'd0, ok}, 32'd0);
      rd_chk(A_WPTR, 32'd0, "R3 wptr");
      exp_q.delete();

      // R2, R4, R5, R6 short capture
      wr(A_CTRL, 32'd1);
      rd_chk(A_STAT, 32'd0, "R2 status cleared");
      check("R2 tr_ready", {31'd0, tr_ready}, 32'd1);
      push_n(5, n);
      check("R4 taken", n, 5);
      rd_chk(A_RDAT, 32'hFFFF_FFFF, "R13 rdata while running");
      wr(A_CTRL, 32'd0);
      tick();
      rd_chk(A_STAT, 32'd4, "R5 ready");
      rd_chk(A_WPTR, 32'd5, "R4 wptr");
      rd_chk(A_RPTR, 32'd0, "R6 rptr unwrapped");
      drain("R6 short");

      // R2 restart, R4 wrap, R6 oldest-first
      wr(A_CTRL, 32'd1);
      rd_chk(A_WPTR, 32'd0, "R2 wptr");
      rd_chk(A_RPTR, 32'd0, "R2 rptr");
      push_n(20, n);
      wr(A_CTRL, 32'd0);
      tick();
      rd_chk(A_STAT, 32'd5, "R4 full+ready");
      rd_chk(A_WPTR, 32'd4, "R4 wrapped wptr");
      rd_chk(A_RPTR, 32'd4, "R6 rptr oldest");
      drain("R6 wrapped");

      // R8 trigger ignored
      wr(A_FLSH, 32'd0);
      restart();
      pulse_trig();
      rd_chk(A_STAT, 32'd0, "R8 no trigger");

      // R7 count of three
      wr(A_TRGC, 32'd3);
      wr(A_FLSH, 32'h100);
      restart();
      push_n(4, n);
      pulse_trig();
      rd_chk(A_STAT, 32'd2, "R7 triggered");
      push_n(6, n);
      check("R7 words after trigger", n, 3);
      tick();
      rd_chk(A_STAT, 32'd6, "R7 stopped");
      drain("R7 readout");

      // R7 count of zero
      wr(A_TRGC, 32'd0);
      restart();
      push_n(2, n);
      pulse_trig();
      push_n(3, n);
      check("R7 zero count", n, 0);
      tick();
      rd_chk(A_STAT, 32'd6, "R7 zero stopped");
      drain("R7 zero readout");

      // R9, R10 flush with stop
      wr(A_FLSH, 32'h1000);
      restart();
      push_n(1, n);
      wr(A_FLSH, 32'h1040);
      rd_chk(A_FLSH, 32'h1040, "R9 flush busy");
      rd_chk(A_FLSH, 32'h1000, "R9 flush cleared");
      check("R10 stopped by flush", {31'd0, tr_ready}, 32'd0);
      rd_chk(A_STAT, 32'd4, "R10 ready");
      drain("R10 readout");

      // R10 flush without stop
      wr(A_FLSH, 32'd0);
      restart();
      wr(A_FLSH, 32'h40);
      tick();
      tick();
      check("R10 keeps running", {31'd0, tr_ready}, 32'd1);
      rd_chk(A_FLSH, 32'd0, "R9 flush done");

      // R11 trigger starts flush
      wr(A_TRGC, 32'd200);
      wr(A_FLSH, 32'h1120);
      restart();
      push_n(2, n);
      pulse_trig();
      tick();
      tick();
      rd_chk(A_STAT, 32'd6, "R11 triggered flush stop");
      check("R11 tr_ready", {31'd0, tr_ready}, 32'd0);
      drain("R11 readout");

      // R12 mode gating
      wr(A_CTRL, 32'd0);
      wr(A_FLSH, 32'd0);
      wr(A_MODE, 32'd1);
      rd_chk(A_MODE, 32'd1, "R12 mode readback");
      wr(A_CTRL, 32'd1);
      check("R12 fifo mode closed", {31'd0, tr_ready}, 32'd0);
      wr(A_MODE, 32'd0);
      check("R12 circular open", {31'd0, tr_ready}, 32'd1);
      wr(A_CTRL, 32'd0);

      // R13 unmapped offsets
      rd_chk(4'd9, 32'd0, "R13 unmapped 9");
      rd_chk(4'd15, 32'd0, "R13 unmapped 15");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule